// File: doc/BRIEF.md
# Serial Converter Output Shifter

This block models the digital output side of a sampling converter whose result is read out with an externally supplied data clock. That clock may stop for any length of time between its pulses. A falling edge on the active-low read/convert request starts a conversion, provided the active-low chip select is held low. A two-flop synchroniser and an edge detector take the request into the system clock domain. The busy line, active low, stays low for a fixed number of system-clock cycles set by a parameter. When the conversion ends, the block latches the result word from its parallel input.

The data clock is sampled in the system clock domain, and each of its rising edges advances the serial output. Pulse 0 raises a one-pulse frame marker. Pulse 1 drops the marker and drives the most significant result bit, and pulses 2 to 16 drive the remaining bits down to bit 0. From pulse 17 onward, the serial pin forwards the chain input as it was sampled sixteen pulses earlier. The first forwarded value is the one taken at pulse 1, so several units can be daisy-chained on one serial line.

Top module: `conv_out_shifter`

## Requirements
- R1: After reset the busy line is high (idle), the frame marker is low and the serial data pin is low.
- R2: A falling edge on the request input while chip select is low drives the busy line low on the third system-clock edge after the request falls.
- R3: A falling edge on the request input while chip select is high starts no conversion, and the busy line stays high.
- R4: The busy line stays low for exactly CONV_CYCLES system-clock cycles and then returns high.
- R5: A request edge that arrives while the busy line is low is ignored: the conversion neither restarts nor stretches.
- R6: On the first data-clock rising edge after busy returns high (pulse 0), the frame marker goes high. The next rising edge (pulse 1) returns it low.
- R7: On the rising edges of pulses 1 to 16, the serial pin shows result bits 15 down to 0 in turn, most significant bit first.
- R8: From pulse 17 onward, the serial pin shows the chain input as it was sampled at the rising edge sixteen pulses earlier. At pulse 17 that is the value sampled at pulse 1, and later values follow one per pulse.
- R9: The marker and serial pin change only on data-clock rising edges and hold their values through any gap in the data clock.
- R10: Data-clock pulses that arrive during a conversion raise no frame marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_n_i | input | 1 | Read/convert request, falling edge starts a conversion |
| cs_n_i | input | 1 | Chip select, active low |
| dclk_i | input | 1 | External data clock, sampled by clk, may be gapped |
| result_i | input | RES_W | Result word latched at the end of a conversion |
| tag_i | input | 1 | Chain input forwarded after the result |
| busy_n_o | output | 1 | Low while a conversion is in progress |
| sync_o | output | 1 | Frame marker pulse ahead of each word |
| data_o | output | 1 | Serial data, MSB first, then the delayed chain input |

## Verification
The busy line falls on the third system-clock edge after the request falls. The bench drives the request at a falling clock edge and expects busy low at the third falling edge that follows. It then counts the falling-edge samples taken while busy is low and expects exactly CONV_CYCLES of them, including when a second request arrives mid-conversion. Every serial output updates on the first system-clock edge that sees the data clock high. The bench therefore samples the marker and data pin at the falling edge after each data-clock high phase, and samples them again at the end of each gap of varying length to confirm they held. The expected bit after pulse k is computed from the result word for k up to 16 and from the bench's own record of the chain input for later pulses.

// File: rtl/conv_out_pkg.sv
package conv_out_pkg;
  typedef enum logic [1:0] {
    PH_WAIT   = 2'd0,
    PH_ARMED  = 2'd1,
    PH_FIRST  = 2'd2,
    PH_STREAM = 2'd3
  } out_phase_e;
endpackage

// File: rtl/rc_edge_sync.sv
module rc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rc_n_i,
  input  logic cs_n_i,
  output logic req_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], rc_n_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  // falling edge on the synchronised request, qualified by chip select
  assign req_o = pipe_q[DEPTH-1] & ~pipe_q[DEPTH-2] & ~cs_n_i;

endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CONV_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic busy_n_o,
  output logic accept_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic             busy_n_q, busy_n_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign accept_o = busy_n_q & req_i;
  assign done_o   = ~busy_n_q & (cnt_q == '0);

  always_comb begin
    busy_n_d = busy_n_q;
    cnt_d    = cnt_q;
    if (accept_o) begin
      busy_n_d = 1'b0;
      cnt_d    = CNT_LOAD;
    end else if (!busy_n_q) begin
      if (cnt_q == '0) busy_n_d = 1'b1;
      else             cnt_d    = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_n_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      busy_n_q <= busy_n_d;
      cnt_q    <= cnt_d;
    end
  end

  assign busy_n_o = busy_n_q;

  // R5: while converting, requests never reload the counter
  assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n_q && cnt_q != '0) |=> (!busy_n_q && cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R4: the conversion ends when the counter runs out
  assert_conv_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n_q && cnt_q == '0) |=> busy_n_q);

endmodule

// File: rtl/serial_out.sv
module serial_out
  import conv_out_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dclk_i,
  input  logic             start_i,
  input  logic             load_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             tag_i,
  output logic             sync_o,
  output logic             data_o
);
  out_phase_e       phase_q, phase_d;
  logic [RES_W-1:0] res_q, res_d;
  logic [RES_W-1:0] sr_q, sr_d;
  logic             dclk_q;
  logic             sync_q, sync_d;
  logic             data_q, data_d;
  logic             rise;

  assign rise = dclk_i & ~dclk_q;

  always_comb begin
    phase_d = phase_q;
    res_d   = res_q;
    sr_d    = sr_q;
    sync_d  = sync_q;
    data_d  = data_q;
    if (rise) begin
      unique case (phase_q)
        PH_WAIT: sync_d = 1'b0;
        PH_ARMED: begin
          sync_d  = 1'b1;
          phase_d = PH_FIRST;
        end
        PH_FIRST: begin
          sync_d  = 1'b0;
          data_d  = res_q[RES_W-1];
          sr_d    = {res_q[RES_W-2:0], tag_i};
          phase_d = PH_STREAM;
        end
        PH_STREAM: begin
          data_d = sr_q[RES_W-1];
          sr_d   = {sr_q[RES_W-2:0], tag_i};
        end
        default: phase_d = PH_WAIT;
      endcase
    end
    if (load_i) begin
      res_d   = result_i;
      phase_d = PH_ARMED;
    end else if (start_i) begin
      phase_d = PH_WAIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      res_q   <= '0;
      sr_q    <= '0;
      dclk_q  <= 1'b0;
      sync_q  <= 1'b0;
      data_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      res_q   <= res_d;
      sr_q    <= sr_d;
      dclk_q  <= dclk_i;
      sync_q  <= sync_d;
      data_q  <= data_d;
    end
  end

  assign sync_o = sync_q;
  assign data_o = data_q;

  // R9: outputs hold whenever the data clock shows no rising edge
  assert_hold_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> ($stable(data_o) && $stable(sync_o)));

  // R6: the marker lasts a single data-clock pulse
  assert_sync_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && rise) |=> !sync_o);

  // R7: pulse 1 drives the most significant result bit
  assert_msb_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FIRST && rise) |=> (data_o == $past(res_q[RES_W-1])));

  // R10: no marker unless a finished result is waiting
  assert_no_early_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_ARMED && rise) |=> !sync_o);

endmodule

// File: rtl/conv_out_shifter.sv
module conv_out_shifter #(
  parameter int RES_W       = 16,
  parameter int CONV_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rc_n_i,
  input  logic             cs_n_i,
  input  logic             dclk_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             tag_i,
  output logic             busy_n_o,
  output logic             sync_o,
  output logic             data_o
);
  logic req;
  logic accept;
  logic done;

  rc_edge_sync #(.STAGES(SYNC_STAGES)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .rc_n_i (rc_n_i),
    .cs_n_i (cs_n_i),
    .req_o  (req)
  );

  conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req),
    .busy_n_o (busy_n_o),
    .accept_o (accept),
    .done_o   (done)
  );

  serial_out #(.RES_W(RES_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .dclk_i   (dclk_i),
    .start_i  (accept),
    .load_i   (done),
    .result_i (result_i),
    .tag_i    (tag_i),
    .sync_o   (sync_o),
    .data_o   (data_o)
  );

  // R2: an accepted request pulls busy low on the next edge
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && busy_n_o) |=> !busy_n_o);

endmodule

// File: tb/conv_out_shifter_tb.sv
module conv_out_shifter_tb_top;
  localparam int W    = 16;
  localparam int CONV = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rc_n = 1'b1;
  logic         cs_n = 1'b0;
  logic         dclk = 1'b0;
  logic [W-1:0] result = '0;
  logic         tag = 1'b0;
  logic         busy_n, sync, data;
  int           errors = 0;
  int           checks = 0;
  logic         tg [0:31];

  always #2.5 clk = ~clk;

  conv_out_shifter #(.RES_W(W), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .rc_n_i(rc_n), .cs_n_i(cs_n), .dclk_i(dclk),
    .result_i(result), .tag_i(tag), .busy_n_o(busy_n), .sync_o(sync), .data_o(data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one conversion; retrig sends a second request mid-conversion, tog pulses dclk meanwhile
  task automatic do_conv(input logic [W-1:0] val, input bit retrig, input bit tog);
    int lat = 0;
    int n = 0;
    result = val;
    @(negedge clk);
    rc_n = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      lat = i;
      if (!busy_n) break;
    end
    check(lat == 3 && !busy_n, "R2 busy fall latency", lat, 3);
    rc_n = 1'b1;
    while (!busy_n) begin
      n++;
      if (retrig && n == 5) rc_n = 1'b0;
      if (retrig && n == 9) rc_n = 1'b1;
      if (tog) begin
        dclk = (n % 4 == 1);
        check(sync == 1'b0, "R10 no marker during conversion", sync, 0);
      end
      @(negedge clk);
    end
    dclk = 1'b0;
    rc_n = 1'b1;
    check(n == CONV, retrig ? "R5 busy length with ignored request" : "R4 busy length", n, CONV);
  endtask

  task automatic pulse(input int hi, input int lo, output logic s_hi, output logic d_hi, output logic d_lo);
    dclk = 1'b1;
    repeat (hi) @(negedge clk);
    s_hi = sync;
    d_hi = data;
    dclk = 1'b0;
    repeat (lo) @(negedge clk);
    d_lo = data;
  endtask

  task automatic read_word(input logic [W-1:0] val, input int seed);
    logic s_hi, d_hi, d_lo;
    logic exp;
    repeat (2) @(negedge clk);
    check(sync == 1'b0, "R6 marker low before pulse 0", sync, 0);
    for (int k = 0; k <= 22; k++) begin
      tg[k] = ((k * 5 + seed) % 3) == 0;
      tag = tg[k];
      pulse(1 + (k % 2), 1 + (k % 4) * 2, s_hi, d_hi, d_lo);
      if (k == 0) begin
        check(s_hi == 1'b1, "R6 marker high at pulse 0", s_hi, 1);
      end else begin
        check(s_hi == 1'b0, "R6 marker low after pulse 0", s_hi, 0);
        if (k <= W) begin
          exp = val[W - k];
          check(d_hi == exp, "R7 result bit", d_hi, exp);
        end else begin
          exp = tg[k - W];
          check(d_hi == exp, "R8 forwarded chain bit", d_hi, exp);
        end
        check(d_lo == exp, "R9 data held through gap", d_lo, exp);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy_n == 1'b1, "R1 busy idle in reset", busy_n, 1);
    check(sync == 1'b0, "R1 marker low in reset", sync, 0);
    check(data == 1'b0, "R1 data low in reset", data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy_n == 1'b1 && sync == 1'b0 && data == 1'b0, "R1 idle after reset", busy_n, 1);

    // R3: request with chip select high
    cs_n = 1'b1;
    rc_n = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(busy_n == 1'b1, "R3 request ignored with chip select high", busy_n, 1);
    end
    rc_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);

    do_conv(16'hA5C3, 1'b0, 1'b0);
    read_word(16'hA5C3, 1);
    do_conv(16'h8001, 1'b1, 1'b0);
    read_word(16'h8001, 2);
    do_conv(16'h7FFE, 1'b0, 1'b1);
    read_word(16'h7FFE, 0);
    do_conv(16'hFFFF, 1'b0, 1'b0);
    read_word(16'hFFFF, 4);
    do_conv(16'h0000, 1'b1, 1'b1);
    read_word(16'h0000, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule